// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-side directory for a slice of distributed shared memory. For every memory line it owns, it keeps one of three states: uncached, shared or exclusive. It also keeps a per-node sharer bit-vector and the identity of the exclusive owner. Nodes present read-miss, write-miss and writeback requests over a per-node valid/ready handshake. The controller accepts one request at a time and answers it with a serial stream of outgoing messages on a single message port: data replies, invalidates, owner fetches and memory writes. It never sends more than one message per cycle.

Accepting a request commits the directory's new view of the line in the same clock edge. A small state machine then plays out the message sequence for that request. The state machine has six states. IDLE accepts requests. INVAL sends one invalidate per cycle to each remaining sharer. FETCH asks the current owner for its copy. MEMWR writes the fetched copy to memory. REPLY sends data to the requester. WBWR writes a writeback to memory. The transitions are as follows. IDLE goes to REPLY, INVAL, FETCH or WBWR, or stays in IDLE, depending on the request kind and the line state. INVAL repeats until no sharers are pending and then goes to REPLY. FETCH goes to MEMWR, and MEMWR goes to REPLY. REPLY and WBWR both return to IDLE. While any state other than IDLE is active, `busy` is high and no request is accepted. This is how the directory orders competing writers.

Top module: `coh_directory`

## Requirements
- R1: After reset every line is uncached with no sharers, and `busy`, `msg_valid` and `req_ready` are all low. The first read of any line therefore yields only a data reply.
- R2: A read miss (kind 0) to an uncached line produces a single data message (kind 0) to the requester and leaves the line shared with the requester as its only sharer.
- R3: A write miss (kind 1) to an uncached line produces a single data message to the requester and makes the line exclusive with the requester as owner.
- R4: A read miss to a shared line produces a single data message and adds the requester to the sharer set.
- R5: A write miss to a shared line sends an invalidate (message kind 1) to every sharer except the requester, one per cycle in ascending node order. A data message follows, and the line becomes exclusive to the requester.
- R6: A read miss to an exclusive line sends, on consecutive cycles, a fetch (kind 2) to the owner, a memory write (kind 3) tagged with the owner, and a data message to the requester. The line becomes shared by exactly the old owner and the requester.
- R7: A write miss to an exclusive line sends fetch to the old owner, memory write, then data to the requester. The line stays exclusive with the requester as new owner.
- R8: A writeback (kind 2) from the owner of an exclusive line produces one memory write tagged with that node and makes the line uncached.
- R9: A writeback from a node that is not the exclusive owner, and any request of kind 3, is accepted but sends no message, leaves `busy` low and leaves the line unchanged.
- R10: With several `req_valid` bits high, `req_ready` goes only to the lowest-numbered valid node, and only while the controller is idle.
- R11: The messages of one request occupy back-to-back cycles, every message carries the request's line, `busy` is high exactly on those cycles, and it falls in the cycle after the final data or memory-write message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_NODES | Per-node request pending |
| req_kind | input | N_NODES x 2 | Per-node kind: 0 read miss, 1 write miss, 2 writeback, 3 none |
| req_line | input | N_NODES x LINE_W | Per-node line index |
| req_ready | output | N_NODES | One-hot accept; request taken at a clock edge where valid and ready are both high |
| busy | output | 1 | Message sequence in progress |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 memory write |
| msg_node | output | NODE_W | Destination node, or source node for a memory write |
| msg_line | output | LINE_W | Line the message refers to |

## Verification
The assertions take two things for granted. First, a node keeps its valid, kind and line steady until it sees ready. Second, the directory's stored states only ever hold the three legal encodings. Within those limits, they require that ready is one-hot and idle-only, that no invalidate targets the requester, and that a fetch is always followed by a memory write to the same node. Within the same limits they also require that the sequence has no gaps and ends in the cycle after its data reply. The stimulus drops a request's valid in the cycle after its handshake and raises new requests only at idle. It mixes random nodes, kinds and a small set of lines, so that lines move through every state, with directed sequences and simultaneous requests. It also covers self-directed cases such as an owner re-reading its own line, which follow the same rules.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_UNC = 2'd0,
        LN_SH  = 2'd1,
        LN_EX  = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        RQ_RD  = 2'd0,
        RQ_WR  = 2'd1,
        RQ_WB  = 2'd2,
        RQ_NOP = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        MS_DATA  = 2'd0,
        MS_INV   = 2'd1,
        MS_FETCH = 2'd2,
        MS_MEMWR = 2'd3
    } msg_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INVAL = 3'd1,
        ST_FETCH = 3'd2,
        ST_MEMWR = 3'd3,
        ST_REPLY = 3'd4,
        ST_WBWR  = 3'd5
    } fsm_t;

endpackage

// File: rtl/coh_lowest_bit.sv
module coh_lowest_bit #(
    parameter int WIDTH = 4,
    parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_pkg::*;
#(
    parameter int N_NODES = 4,
    parameter int N_LINES = 8,
    parameter int NODE_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    parameter int LINE_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  rd_line,
    output line_st_t           rd_state,
    output logic [N_NODES-1:0] rd_sharers,
    output logic [NODE_W-1:0]  rd_owner,
    input  logic               wr_en,
    input  logic [LINE_W-1:0]  wr_line,
    input  line_st_t           wr_state,
    input  logic [N_NODES-1:0] wr_sharers,
    input  logic [NODE_W-1:0]  wr_owner
);
    line_st_t           st_q  [N_LINES];
    logic [N_NODES-1:0] sh_q  [N_LINES];
    logic [NODE_W-1:0]  own_q [N_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LINES; i++) begin
                st_q[i]  <= LN_UNC;
                sh_q[i]  <= '0;
                own_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_line]  <= wr_state;
            sh_q[wr_line]  <= wr_sharers;
            own_q[wr_line] <= wr_owner;
        end
    end

    assign rd_state   = st_q[rd_line];
    assign rd_sharers = sh_q[rd_line];
    assign rd_owner   = own_q[rd_line];

    // A shared line always has at least one sharer recorded (R4)
    assert_shared_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == LN_SH) |-> (rd_sharers != '0));

    // Stored state is one of the three legal encodings (R1)
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_state != line_st_t'(2'd3));
endmodule

// File: rtl/coh_directory.sv
module coh_directory
    import coh_pkg::*;
#(
    parameter int N_NODES = 4,
    parameter int N_LINES = 8,
    parameter int NODE_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    parameter int LINE_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_NODES-1:0]             req_valid,
    input  logic [N_NODES-1:0][1:0]        req_kind,
    input  logic [N_NODES-1:0][LINE_W-1:0] req_line,
    output logic [N_NODES-1:0]             req_ready,
    output logic                           busy,
    output logic                           msg_valid,
    output logic [1:0]                     msg_kind,
    output logic [NODE_W-1:0]              msg_node,
    output logic [LINE_W-1:0]              msg_line
);
    fsm_t               fsm_q, fsm_d;
    logic [NODE_W-1:0]  cur_node_q;
    logic [LINE_W-1:0]  cur_line_q;
    logic [NODE_W-1:0]  peer_q;
    logic [N_NODES-1:0] pend_q, pend_d;

    logic [NODE_W-1:0]  sel_idx;
    logic               sel_any;
    req_kind_t          sel_kind;
    logic [LINE_W-1:0]  sel_line;
    logic               accept;
    logic [N_NODES-1:0] bit_req, pend_other, inv_bit;
    logic [NODE_W-1:0]  inv_idx;
    logic               inv_any;

    line_st_t           rd_state;
    logic [N_NODES-1:0] rd_sharers;
    logic [NODE_W-1:0]  rd_owner;
    logic               wr_en;
    line_st_t           wr_state;
    logic [N_NODES-1:0] wr_sharers;
    logic [NODE_W-1:0]  wr_owner;

    coh_lowest_bit #(.WIDTH(N_NODES), .IDX_W(NODE_W)) u_pick (
        .vec(req_valid), .idx(sel_idx), .any(sel_any)
    );

    coh_lowest_bit #(.WIDTH(N_NODES), .IDX_W(NODE_W)) u_inv_scan (
        .vec(pend_q), .idx(inv_idx), .any(inv_any)
    );

    coh_line_table #(.N_NODES(N_NODES), .N_LINES(N_LINES),
                     .NODE_W(NODE_W), .LINE_W(LINE_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_line(sel_line), .rd_state(rd_state),
        .rd_sharers(rd_sharers), .rd_owner(rd_owner),
        .wr_en(wr_en), .wr_line(sel_line), .wr_state(wr_state),
        .wr_sharers(wr_sharers), .wr_owner(wr_owner)
    );

    assign sel_kind = req_kind_t'(req_kind[sel_idx]);
    assign sel_line = req_line[sel_idx];
    assign accept   = (fsm_q == ST_IDLE) && sel_any;

    always_comb begin
        bit_req = '0;
        bit_req[sel_idx] = 1'b1;
        inv_bit = '0;
        inv_bit[inv_idx] = 1'b1;
        req_ready = accept ? bit_req : '0;
        pend_other = rd_sharers & ~bit_req;
    end

    // Decision taken when a request is accepted: new line view and first step
    always_comb begin
        wr_en      = 1'b0;
        wr_state   = rd_state;
        wr_sharers = rd_sharers;
        wr_owner   = rd_owner;
        fsm_d      = fsm_q;
        pend_d     = pend_q;
        unique case (fsm_q)
            ST_IDLE: begin
                pend_d = pend_other;
                if (accept) begin
                    unique case (sel_kind)
                        RQ_RD: begin
                            wr_en = 1'b1;
                            wr_state = LN_SH;
                            if (rd_state == LN_EX) begin
                                wr_sharers = bit_req;
                                wr_sharers[rd_owner] = 1'b1;
                                fsm_d = ST_FETCH;
                            end else if (rd_state == LN_SH) begin
                                wr_sharers = rd_sharers | bit_req;
                                fsm_d = ST_REPLY;
                            end else begin
                                wr_sharers = bit_req;
                                fsm_d = ST_REPLY;
                            end
                        end
                        RQ_WR: begin
                            wr_en = 1'b1;
                            wr_state = LN_EX;
                            wr_sharers = bit_req;
                            wr_owner = sel_idx;
                            if (rd_state == LN_EX)
                                fsm_d = ST_FETCH;
                            else if (rd_state == LN_SH && pend_other != '0)
                                fsm_d = ST_INVAL;
                            else
                                fsm_d = ST_REPLY;
                        end
                        RQ_WB: begin
                            if (rd_state == LN_EX && rd_owner == sel_idx) begin
                                wr_en = 1'b1;
                                wr_state = LN_UNC;
                                wr_sharers = '0;
                                fsm_d = ST_WBWR;
                            end
                        end
                        RQ_NOP: ;
                    endcase
                end
            end
            ST_INVAL: begin
                pend_d = pend_q & ~inv_bit;
                if (pend_d == '0)
                    fsm_d = ST_REPLY;
            end
            ST_FETCH: fsm_d = ST_MEMWR;
            ST_MEMWR: fsm_d = ST_REPLY;
            ST_REPLY: fsm_d = ST_IDLE;
            ST_WBWR:  fsm_d = ST_IDLE;
            default:  fsm_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q      <= ST_IDLE;
            cur_node_q <= '0;
            cur_line_q <= '0;
            peer_q     <= '0;
            pend_q     <= '0;
        end else begin
            fsm_q  <= fsm_d;
            pend_q <= pend_d;
            if (accept) begin
                cur_node_q <= sel_idx;
                cur_line_q <= sel_line;
                peer_q     <= rd_owner;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (fsm_q != ST_IDLE);
        msg_valid = 1'b1;
        msg_kind  = MS_DATA;
        msg_node  = cur_node_q;
        msg_line  = cur_line_q;
        unique case (fsm_q)
            ST_IDLE:  msg_valid = 1'b0;
            ST_INVAL: begin msg_kind = MS_INV;   msg_node = inv_idx; end
            ST_FETCH: begin msg_kind = MS_FETCH; msg_node = peer_q;  end
            ST_MEMWR: begin msg_kind = MS_MEMWR; msg_node = peer_q;  end
            ST_REPLY: msg_kind = MS_DATA;
            ST_WBWR:  msg_kind = MS_MEMWR;
            default:  msg_valid = 1'b0;
        endcase
    end

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |-> !busy);

    assert_ready_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

    assert_no_self_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MS_INV) |-> (msg_node != cur_node_q));

    assert_fetch_then_memwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MS_FETCH) |=>
            (msg_valid && msg_kind == MS_MEMWR && $stable(msg_node)));

    assert_no_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> msg_valid);

    assert_data_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MS_DATA) |=> !busy);
endmodule

// File: tb/coh_directory_bench.sv
module coh_directory_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NN = 4;
    localparam int NL = 8;
    localparam int NW = 2;
    localparam int LW = 3;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NN-1:0]             req_valid = '0;
    logic [NN-1:0][1:0]        req_kind = '0;
    logic [NN-1:0][LW-1:0]     req_line = '0;
    logic [NN-1:0]             req_ready;
    logic                      busy, msg_valid;
    logic [1:0]                msg_kind;
    logic [NW-1:0]             msg_node;
    logic [LW-1:0]             msg_line;

    int checks = 0;
    int errors = 0;

    // model: 0 uncached, 1 shared, 2 exclusive
    int m_st [NL];
    int m_sh [NL];
    int m_own[NL];
    int ek[32], en[32], ecnt;
    int gk[32], gn[32], gl[32], gcnt;
    string etag;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_directory #(.N_NODES(NN), .N_LINES(NL)) u_coh_directory (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_line(req_line), .req_ready(req_ready), .busy(busy),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
        .msg_line(msg_line)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input int n);
        ek[ecnt] = k; en[ecnt] = n; ecnt++;
    endtask

    // Expected messages and new directory view, from the requirements
    task automatic model(input int n, input int k, input int l);
        ecnt = 0;
        if (k == 0) begin
            if (m_st[l] == 0) begin
                etag = "R2"; push(0, n); m_sh[l] = 1 << n;
            end else if (m_st[l] == 1) begin
                etag = "R4"; push(0, n); m_sh[l] |= 1 << n;
            end else begin
                etag = "R6"; push(2, m_own[l]); push(3, m_own[l]); push(0, n);
                m_sh[l] = (1 << n) | (1 << m_own[l]);
            end
            m_st[l] = 1;
        end else if (k == 1) begin
            if (m_st[l] == 0) begin
                etag = "R3"; push(0, n);
            end else if (m_st[l] == 1) begin
                etag = "R5";
                for (int i = 0; i < NN; i++)
                    if (((m_sh[l] >> i) & 1) == 1 && i != n) push(1, i);
                push(0, n);
            end else begin
                etag = "R7"; push(2, m_own[l]); push(3, m_own[l]); push(0, n);
            end
            m_st[l] = 2; m_own[l] = n; m_sh[l] = 1 << n;
        end else if (k == 2 && m_st[l] == 2 && m_own[l] == n) begin
            etag = "R8"; push(3, n); m_st[l] = 0; m_sh[l] = 0;
        end else begin
            etag = "R9";
        end
    endtask

    task automatic collect(input int l);
        int guard;
        bit ok;
        int bad;
        gcnt = 0; guard = 0; ok = 1; bad = -1;
        @(negedge clk);
        while (busy && guard < 32) begin
            if (!msg_valid) ok = 0;
            gk[gcnt] = msg_kind; gn[gcnt] = msg_node; gl[gcnt] = msg_line;
            gcnt++; guard++;
            @(negedge clk);
        end
        if (msg_valid) ok = 0;
        if (gcnt != ecnt) ok = 0;
        for (int i = 0; i < gcnt && i < ecnt; i++) begin
            if (ok && (gk[i] != ek[i] || gn[i] != en[i] || gl[i] != l)) begin
                ok = 0; bad = i;
            end
        end
        if (bad >= 0)
            check(0, {etag, " R11 message kind*10+node"}, gk[bad]*10 + gn[bad], ek[bad]*10 + en[bad]);
        else
            check(ok, {etag, " R11 message count"}, gcnt, ecnt);
    endtask

    // Handshake for a node whose valid is already raised; ends at the negedge after the sequence
    task automatic finish_req(input int n);
        int k, l;
        k = req_kind[n]; l = req_line[n];
        while (!req_ready[n]) @(negedge clk);
        @(posedge clk);
        #1 req_valid[n] = 1'b0;
        model(n, k, l);
        collect(l);
    endtask

    task automatic do_req(input int n, input int k, input int l);
        req_kind[n] = 2'(k); req_line[n] = 3'(l); req_valid[n] = 1'b1;
        #1;
        finish_req(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240601));
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_sh[i] = 0; m_own[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !msg_valid && req_ready == '0, "R1 idle after reset", {busy, msg_valid}, 0);

        // R1: every line starts uncached
        for (int l = 0; l < NL; l++) begin
            do_req(l % NN, 0, l);
            check(etag == "R2", "R1 first read is plain", ecnt, 1);
        end
        rst_n = 1'b0;
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_sh[i] = 0; end
        @(negedge clk); rst_n = 1'b1; @(negedge clk);

        // Directed walk on line 5
        do_req(0, 0, 5);   // R2
        do_req(1, 0, 5);   // R4
        do_req(2, 0, 5);   // R4
        do_req(3, 1, 5);   // R5: invalidates 0,1,2
        do_req(0, 0, 5);   // R6
        do_req(1, 1, 5);   // R5: invalidates 0,3
        do_req(2, 1, 5);   // R7
        do_req(0, 2, 5);   // R9 non-owner writeback
        do_req(2, 2, 5);   // R8
        do_req(2, 2, 5);   // R9 line now uncached
        do_req(1, 3, 5);   // R9 kind 3
        do_req(3, 1, 5);   // R3
        do_req(3, 0, 5);   // R6 owner re-reads
        do_req(3, 1, 5);   // R5 sole sharer writes: no invalidates

        // R9: ignored request leaves busy low
        req_kind[0] = 2'd3; req_line[0] = 3'd2; req_valid[0] = 1'b1;
        #1;
        @(posedge clk); #1 req_valid[0] = 1'b0;
        @(negedge clk);
        check(!busy && !msg_valid, "R9 no activity", {busy, msg_valid}, 0);

        // R10: simultaneous requests, lowest id first
        req_kind[3] = 2'd1; req_line[3] = 3'd6; req_valid[3] = 1'b1;
        req_kind[1] = 2'd1; req_line[1] = 3'd6; req_valid[1] = 1'b1;
        #1;
        check(req_ready == 4'b0010, "R10 priority grant", req_ready, 2);
        finish_req(1);
        #1;
        check(req_ready == 4'b1000, "R10 next grant", req_ready, 8);
        finish_req(3);

        // Random mix, occasionally with a competing lower-priority request
        for (int t = 0; t < 400; t++) begin
            int n, k, l, n2;
            n = $urandom % NN;
            k = $urandom % 4;
            if ($urandom % 8 == 0) k = 3;
            l = $urandom % 3;
            if ($urandom % 5 == 0 && n < NN - 1) begin
                n2 = n + 1 + ($urandom % (NN - 1 - n));
                req_kind[n2] = 2'($urandom % 3); req_line[n2] = 3'(l); req_valid[n2] = 1'b1;
                req_kind[n] = 2'(k); req_line[n] = 3'(l); req_valid[n] = 1'b1;
                #1;
                check(req_ready == 4'(1 << n), "R10 random priority", req_ready, 1 << n);
                finish_req(n);
                #1;
                finish_req(n2);
            end else begin
                do_req(n, k, l);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule